// File: doc/BRIEF.md
# Host Block Staging Buffer

This block sits between a byte-wide host register port and a SCSI transfer engine and stages one 128-byte block at a time. A direction bit in a control/status register picks the mode. When sending, the host fills the buffer and the engine drains it. When receiving, the engine fills the buffer and the host drains it. A not-ready flag tells the host when its side of the buffer may be touched. An 8-bit block counter, loaded by the host, counts the blocks that remain.

The engine sees the storage through its own address, write and read-data pins, along with the current direction and the not-ready flag. Each time it finishes a block it sends a single-cycle completion pulse. That pulse hands the buffer back to the host and decrements the counter. A busy state starts when the host completes a send block and ends at the next completion pulse. It is shown to the host as an accessible bit that reads 1 only while busy is clear.

Host register select codes: 0 is control/status, 1 is the block counter, 2 is the data port, and 3 reads as 0xFF. Read data is combinational on `host_sel`. A read or write takes effect at the clock edge where its enable is high.

Top module: `hbb_top`

## Requirements
- R1: After reset the status byte reads 0x84 (accessible bit 7 set, not-ready bit 2 set), the counter reads 0 with `cnt_loaded` low, and a data-port read returns 0xFF.
- R2: A control write takes bits 6:3 of the written byte and keeps the held bits. Bits 1:0 read as 0, and bit 2 changes only through the direction rules.
- R3: A control write that changes bit 6 from 0 (send) to 1 (receive) moves the host pointer to 128 and sets not-ready, so host data reads return 0xFF.
- R4: A control write that changes bit 6 from 1 to 0 moves the host pointer to 0 and clears not-ready.
- R5: A counter write loads the value and raises `cnt_loaded`. In receive it also sets pointer 128 with not-ready set. In send it sets pointer 0 with not-ready clear.
- R6: In send, host data writes are stored at successive positions while the pointer is below 128. The write that reaches 128 sets not-ready and busy, so bit 7 reads 0. Later writes change nothing.
- R7: In receive, host data reads return successive bytes while the pointer is below 128, and the read that reaches 128 sets not-ready. Reads in send direction, or with the pointer at 128, return 0xFF and do not advance.
- R8: A completion pulse resets the pointer to 0, clears not-ready and busy, and decrements the counter modulo 256.
- R9: A completion pulse that brings the counter to 0 drops `cnt_loaded`.
- R10: In receive, engine writes land at the addressed position. The engine read port returns the byte at the addressed position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Host register select |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe (advances data port) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for selected register |
| eng_addr | input | 7 | Engine buffer position |
| eng_we | input | 1 | Engine write (honoured in receive) |
| eng_wdata | input | 8 | Engine write data |
| eng_rdata | output | 8 | Byte at engine position |
| eng_dir | output | 1 | Current direction, 1 = receive |
| eng_nrdy | output | 1 | Not-ready flag |
| blk_done | input | 1 | Engine block-complete pulse |
| blk_count | output | 8 | Remaining block count |
| cnt_loaded | output | 1 | Counter has been loaded and not run out |

## Verification
The hardest state to reach is the counter wrapping and the completion pulse arriving while busy is set after a full send block, with a direction toggle mixed in. Each of these needs 128 accepted host accesses first. The directed part fills and drains whole blocks in both directions, runs the counter through 1, 0 and 255, and toggles direction while busy. The seeded random part then mixes control writes, counter loads, data accesses and completion pulses against a bench model, so preloads keep interrupting partial blocks.

// File: rtl/hbb_pkg.sv
`timescale 1ns/1ps
package hbb_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } hbb_sel_e;

    localparam int unsigned DIR_BIT    = 6;
    localparam int unsigned NRDY_BIT   = 2;
    localparam int unsigned ACC_BIT    = 7;
    localparam logic [7:0]  TAKE_MASK  = 8'h78;
    localparam logic [7:0]  EMPTY_BYTE = 8'hFF;

    // Writable control field: bit 6 is direction, bits 5:3 are kept as options
    typedef struct packed {
        logic       dir;
        logic [2:0] opt;
    } hbb_ctrl_t;

    function automatic hbb_ctrl_t take_ctrl(input logic [7:0] wbyte);
        logic [7:0] m;
        m = wbyte & TAKE_MASK;
        return '{dir: m[DIR_BIT], opt: m[5:3]};
    endfunction

    function automatic logic [7:0] pack_status(input hbb_ctrl_t c,
                                               input logic nrdy,
                                               input logic busy);
        logic [7:0] s;
        s = 8'h00;
        s[ACC_BIT]  = ~busy;
        s[DIR_BIT]  = c.dir;
        s[5:3]      = c.opt;
        s[NRDY_BIT] = nrdy;
        return s;
    endfunction
endpackage

// File: rtl/hbb_ctrl_cnt.sv
`timescale 1ns/1ps
module hbb_ctrl_cnt
    import hbb_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic [7:0]       wbyte,
    input  logic             blk_done,
    output hbb_ctrl_t        ctrl_q,
    output logic             to_rx,
    output logic             to_tx,
    output logic [CNT_W-1:0] count_q,
    output logic             loaded_q
);
    hbb_ctrl_t        ctrl_n;
    logic [CNT_W-1:0] count_dec;

    assign ctrl_n    = take_ctrl(wbyte);
    assign to_rx     = ctrl_we &&  ctrl_n.dir && !ctrl_q.dir;
    assign to_tx     = ctrl_we && !ctrl_n.dir &&  ctrl_q.dir;
    assign count_dec = count_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{dir: 1'b0, opt: 3'b000};
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            loaded_q <= 1'b0;
        end else if (cnt_we) begin
            count_q  <= wbyte[CNT_W-1:0];
            loaded_q <= 1'b1;
        end else if (blk_done) begin
            count_q <= count_dec;
            if (count_dec == '0) begin
                loaded_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hbb_ptr_ctl.sv
`timescale 1ns/1ps
module hbb_ptr_ctl #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          to_rx,
    input  logic          to_tx,
    input  logic          cnt_we,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          blk_done,
    output logic [PW-1:0] ptr_q,
    output logic          nrdy_q,
    output logic          busy_q,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic          room
);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    logic [PW-1:0] ptr_inc;

    assign room    = (ptr_q < FULL);
    assign wr_acc  = data_wr && !dir && room && !blk_done;
    assign rd_acc  = data_rd &&  dir && room && !blk_done;
    assign ptr_inc = ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= FULL;
            nrdy_q <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            if (blk_done) begin
                ptr_q  <= '0;
                nrdy_q <= 1'b0;
                busy_q <= 1'b0;
            end
            if (wr_acc) begin
                ptr_q <= ptr_inc;
                if (ptr_inc == FULL) begin
                    nrdy_q <= 1'b1;
                    busy_q <= 1'b1;
                end
            end
            if (rd_acc) begin
                ptr_q <= ptr_inc;
                if (ptr_inc == FULL) begin
                    nrdy_q <= 1'b1;
                end
            end
            if (to_rx) begin
                ptr_q  <= FULL;
                nrdy_q <= 1'b1;
            end
            if (to_tx) begin
                ptr_q  <= '0;
                nrdy_q <= 1'b0;
            end
            if (cnt_we) begin
                ptr_q  <= dir ? FULL : '0;
                nrdy_q <= dir;
            end
        end
    end
endmodule

// File: rtl/hbb_store.sv
`timescale 1ns/1ps
module hbb_store #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];
endmodule

// File: rtl/hbb_top.sv
`timescale 1ns/1ps
module hbb_top
    import hbb_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       host_sel,
    input  logic             host_wr_en,
    input  logic             host_rd_en,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic [AW-1:0]    eng_addr,
    input  logic             eng_we,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       eng_rdata,
    output logic             eng_dir,
    output logic             eng_nrdy,
    input  logic             blk_done,
    output logic [CNT_W-1:0] blk_count,
    output logic             cnt_loaded
);
    hbb_sel_e      sel;
    hbb_ctrl_t     ctrl_q;
    logic          to_rx, to_tx;
    logic          ctrl_we, cnt_we, data_wr, data_rd;
    logic [PW-1:0] ptr;
    logic          nrdy, busy, wr_acc, rd_acc, room;
    logic [7:0]    host_mem_rd;

    assign sel     = hbb_sel_e'(host_sel);
    assign ctrl_we = host_wr_en && (sel == SEL_CTRL);
    assign cnt_we  = host_wr_en && (sel == SEL_COUNT);
    assign data_wr = host_wr_en && (sel == SEL_DATA);
    assign data_rd = host_rd_en && (sel == SEL_DATA);

    hbb_ctrl_cnt #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .cnt_we   (cnt_we),
        .wbyte    (host_wdata),
        .blk_done (blk_done),
        .ctrl_q   (ctrl_q),
        .to_rx    (to_rx),
        .to_tx    (to_tx),
        .count_q  (blk_count),
        .loaded_q (cnt_loaded)
    );

    hbb_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .dir      (ctrl_q.dir),
        .to_rx    (to_rx),
        .to_tx    (to_tx),
        .cnt_we   (cnt_we),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .blk_done (blk_done),
        .ptr_q    (ptr),
        .nrdy_q   (nrdy),
        .busy_q   (busy),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .room     (room)
    );

    hbb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .a_we    (wr_acc),
        .a_addr  (ptr[AW-1:0]),
        .a_wdata (host_wdata),
        .a_rdata (host_mem_rd),
        .b_we    (eng_we && ctrl_q.dir),
        .b_addr  (eng_addr),
        .b_wdata (eng_wdata),
        .b_rdata (eng_rdata)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL:  host_rdata = pack_status(ctrl_q, nrdy, busy);
            SEL_COUNT: host_rdata = 8'(blk_count);
            SEL_DATA:  host_rdata = (ctrl_q.dir && room) ? host_mem_rd : EMPTY_BYTE;
            default:   host_rdata = EMPTY_BYTE;
        endcase
    end

    assign eng_dir  = ctrl_q.dir;
    assign eng_nrdy = nrdy;
endmodule

// File: rtl/hbb_checker.sv
`timescale 1ns/1ps
module hbb_checker #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       host_sel,
    input logic             host_wr_en,
    input logic             blk_done,
    input logic             eng_nrdy,
    input logic [CNT_W-1:0] blk_count,
    input logic             cnt_loaded,
    input logic [PW-1:0]    ptr,
    input logic             busy
);
    a_r7_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(DEPTH));

    a_r8_done_hands_back: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !host_wr_en) |=> (!eng_nrdy && ptr == '0 && !busy));

    a_r8_count_wraps: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !(host_wr_en && host_sel == 2'd1))
            |=> (blk_count == $past(blk_count) - 1'b1));

    a_r6_busy_implies_nrdy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> eng_nrdy);

    a_r5_load_marks: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_sel == 2'd1) |=> cnt_loaded);

    a_r9_zero_unloads: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !host_wr_en && blk_count == CNT_W'(1)) |=> !cnt_loaded);
endmodule

bind hbb_top hbb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_wr_en (host_wr_en),
    .blk_done   (blk_done),
    .eng_nrdy   (eng_nrdy),
    .blk_count  (blk_count),
    .cnt_loaded (cnt_loaded),
    .ptr        (ptr),
    .busy       (busy)
);

// File: tb/tb_hbb_top.sv
`timescale 1ns/1ps
module tb_hbb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] host_sel;
    logic       host_wr_en, host_rd_en;
    logic [7:0] host_wdata, host_rdata;
    logic [6:0] eng_addr;
    logic       eng_we;
    logic [7:0] eng_wdata, eng_rdata;
    logic       eng_dir, eng_nrdy, blk_done, cnt_loaded;
    logic [7:0] blk_count;

    int checks = 0;
    int errors = 0;

    // bench model
    logic       m_dir, m_nrdy, m_busy, m_loaded;
    logic [2:0] m_opt;
    int         m_ptr;
    logic [7:0] m_cnt;
    logic [7:0] m_mem [128];

    always #10 clk = ~clk;

    hbb_top dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr_en(host_wr_en),
        .host_rd_en(host_rd_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata), .eng_dir(eng_dir), .eng_nrdy(eng_nrdy),
        .blk_done(blk_done), .blk_count(blk_count), .cnt_loaded(cnt_loaded)
    );

    function automatic logic [7:0] exp_status();
        return {~m_busy, m_dir, m_opt, m_nrdy, 2'b00};
    endfunction

    function automatic logic [7:0] exp_data();
        return (m_dir && m_ptr < 128) ? m_mem[m_ptr] : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr_en = 0; host_rd_en = 0; eng_we = 0; blk_done = 0;
    endtask

    task automatic host_write(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        host_sel = s; host_wdata = v; host_wr_en = 1;
        @(posedge clk); #1 idle();
        case (s)
            2'd0: begin
                if (v[6] && !m_dir) begin m_ptr = 128; m_nrdy = 1; end
                else if (!v[6] && m_dir) begin m_ptr = 0; m_nrdy = 0; end
                m_dir = v[6]; m_opt = v[5:3];
            end
            2'd1: begin
                m_cnt = v; m_loaded = 1;
                m_ptr = m_dir ? 128 : 0; m_nrdy = m_dir;
            end
            2'd2: if (!m_dir && m_ptr < 128) begin
                m_mem[m_ptr] = v; m_ptr++;
                if (m_ptr == 128) begin m_nrdy = 1; m_busy = 1; end
            end
            default: ;
        endcase
    endtask

    task automatic host_read(input logic [1:0] s, input string req);
        logic [7:0] e;
        @(negedge clk);
        host_sel = s; host_rd_en = 1;
        #2;
        case (s)
            2'd0: e = exp_status();
            2'd1: e = m_cnt;
            2'd2: e = exp_data();
            default: e = 8'hFF;
        endcase
        check(req, host_rdata, e);
        @(posedge clk); #1 idle();
        if (s == 2'd2 && m_dir && m_ptr < 128) begin
            m_ptr++;
            if (m_ptr == 128) m_nrdy = 1;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        blk_done = 1;
        @(posedge clk); #1 idle();
        m_ptr = 0; m_nrdy = 0; m_busy = 0; m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_loaded = 0;
    endtask

    task automatic eng_write(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        eng_addr = a; eng_wdata = v; eng_we = 1;
        @(posedge clk); #1 idle();
        if (m_dir) m_mem[a] = v;
    endtask

    task automatic eng_check(input logic [6:0] a, input string req);
        @(negedge clk);
        eng_addr = a;
        #2 check(req, eng_rdata, m_mem[a]);
    endtask

    task automatic flags(input string req);
        @(negedge clk);
        check(req, {5'b0, eng_dir, eng_nrdy, cnt_loaded}, {5'b0, m_dir, m_nrdy, m_loaded});
        check(req, blk_count, m_cnt);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        idle(); host_sel = 0; host_wdata = 0; eng_addr = 0; eng_wdata = 0;
        rst = 1;
        m_dir = 0; m_nrdy = 1; m_busy = 0; m_loaded = 0; m_opt = 0; m_ptr = 128; m_cnt = 0;
        for (int i = 0; i < 128; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        host_read(2'd0, "R1");
        check("R1 status", host_rdata, 8'h84);
        host_read(2'd1, "R1");
        host_read(2'd2, "R1");
        flags("R1");

        // R2 R3 send->receive
        host_write(2'd0, 8'hFF);
        host_read(2'd0, "R3");
        check("R2 merge", host_rdata, 8'hFC);
        host_read(2'd2, "R3");
        // R4 receive->send
        host_write(2'd0, 8'h00);
        host_read(2'd0, "R4");
        flags("R4");
        // R2 no direction change keeps not-ready
        host_write(2'd0, 8'h2B);
        host_read(2'd0, "R2");
        check("R2 held bits", host_rdata, 8'hA8);

        // R5 counter load in send
        host_write(2'd1, 8'd2);
        host_read(2'd1, "R5");
        flags("R5");

        // R6 fill full block
        for (int i = 0; i < 128; i++) host_write(2'd2, 8'($urandom()));
        host_read(2'd0, "R6");
        check("R6 busy status", host_rdata, 8'h2C);
        host_write(2'd2, 8'h5A);
        for (int i = 0; i < 128; i += 17) eng_check(7'(i), "R10");
        eng_check(7'd0, "R6 ignored write");
        host_read(2'd2, "R7 send read");

        // R8 R9 completions
        pulse_done();
        host_read(2'd0, "R8");
        flags("R8");
        pulse_done();
        flags("R9");
        pulse_done();
        host_read(2'd1, "R8 wrap");
        check("R8 wrap", blk_count, 8'hFF);
        flags("R9 stays");

        // receive block
        host_write(2'd0, 8'h40);
        host_write(2'd1, 8'd1);
        flags("R5 rx preload");
        for (int i = 0; i < 128; i++) eng_write(7'(i), 8'($urandom()));
        eng_check(7'd77, "R10");
        pulse_done();
        flags("R9 rx");
        for (int i = 0; i < 128; i++) host_read(2'd2, "R7");
        host_read(2'd2, "R7 exhausted");
        host_read(2'd0, "R7 nrdy");

        // busy then direction toggle
        host_write(2'd0, 8'h00);
        for (int i = 0; i < 128; i++) host_write(2'd2, 8'(i * 3));
        host_write(2'd0, 8'h40);
        host_read(2'd0, "R3 while busy");
        host_write(2'd0, 8'h08);
        host_read(2'd0, "R4 while busy");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            op = $urandom_range(0, 99);
            if (op < 4)       host_write(2'd0, 8'($urandom()));
            else if (op < 7)  host_write(2'd1, 8'($urandom_range(0, 3)));
            else if (op < 40) host_write(2'd2, 8'($urandom()));
            else if (op < 70) host_read(2'd2, "R7 random");
            else if (op < 78) host_read(2'd0, "R2 random");
            else if (op < 82) host_read(2'd1, "R8 random");
            else if (op < 85) pulse_done();
            else if (op < 93) eng_write(7'($urandom()), 8'($urandom()));
            else              eng_check(7'($urandom()), "R10 random");
        end
        flags("R9 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule